// File: doc/BRIEF.md
# Supervisory Watchdog Timer with Expiry Trip Counter

This block watches over system software with a 32-bit counter that counts down. Software sets a reload count and enables the timer. It must then write a key value to the service register at regular intervals. If the counter reaches zero before that happens, the block drives a reset pulse of fixed length to the core and the peripherals. The counter then reloads and keeps running.

Each expiry is recorded in two ways. A sticky status bit shows that the watchdog caused a reset. A trip counter holds the number of expiries since the last hardware reset. A programmed trip limit turns repeated failure into a permanent condition: when the number of expiries reaches the limit, the reset output stays asserted and the counter freezes. Only the external hardware reset input (`rst_n`) clears the status bit, the trip count and the held reset. The pulsed resets that the block issues itself do not clear them. A trip limit of zero turns the holding behaviour off.

Register map (32-bit data):
- Address 0 is the control register. Bit 0 is the enable. Bit 1 is the status bit, which is read-only.
- Address 1 is the reload count.
- Address 2 is the service register when written and returns the live count when read.
- Address 3 is the trip register. Bits [7:0] hold the trip limit. Bits [15:8] hold the current trip count, which is read-only.

Top module: `wdt_trip_top`

## Requirements
- R1: After a hardware reset, every register reads zero and `rst_out` is low. The register contents are the enable, the status bit, the reload count, the live count, the trip limit and the trip count.
- R2: A write of 1 to control bit 0 while the timer is disabled loads the counter from the reload count on that edge. While enabled, the counter then falls by one each cycle. While disabled, it holds its value.
- R3: Expiry happens on the edge at which the counter is already zero and the timer is enabled. The counter reloads on that edge and keeps counting. `rst_out` rises after that edge and stays high for exactly 16 cycles.
- R4: A write of 0x5AC3_3CA5 to address 2 while the timer is enabled reloads the counter. Any other value written there has no effect on the count. A write of the key while the timer is disabled also has no effect.
- R5: A correct service write on the edge at which the counter is zero wins. The counter reloads, no expiry happens and no reset pulse is issued.
- R6: Control bit 1 is set by the first expiry and stays set until hardware reset. Writes to the control register do not clear it.
- R7: Trip register bits [15:8] increase by one on each expiry and saturate at 255. Pulsed watchdog resets do not clear them.
- R8: Take the trip count after an expiry has been counted. If the trip limit is non-zero and that count is greater than or equal to the limit, `rst_out` is held high from that expiry until hardware reset, and the counter stops.
- R9: With a trip limit of zero, `rst_out` is never held, and each expiry gives only the 16-cycle pulse.
- R10: A hardware reset clears a held `rst_out`, the status bit, the trip count and the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | External hardware reset, active low, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| rst_out | output | 1 | Watchdog reset to the core and peripherals |

## Verification
Two events can fall on the same edge: a service write and an expiry. The bench enables the timer and counts cycles until the live count reads zero. It then issues the key write so that the write lands on the exact expiry edge. The result is judged at the ports. `rst_out` must stay low, the count must read the full reload value, and the status bit and trip count must still be zero. A second case places a terminal expiry while a pulse is still running. It checks that the held reset outlasts the 16-cycle pulse.

// File: rtl/wdt_pkg.sv
// Package: register addresses, service key and shared widths for the watchdog.
// Assumes a 2-bit register address and a data word as wide as the counter.
package wdt_pkg;
    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_LOAD  = 2'd1;
    localparam logic [1:0] ADDR_SVC   = 2'd2;
    localparam logic [1:0] ADDR_TRIP  = 2'd3;
    localparam logic [31:0] SVC_KEY   = 32'h5AC3_3CA5;
    localparam int CTRL_EN_BIT        = 0;
    localparam int CTRL_STAT_BIT      = 1;
endpackage

// File: rtl/wdt_down_counter.sv
// Down counter: loads on a reload request, falls by one per enabled cycle,
// and wraps to the load value on reaching zero, flagging an expiry.
// Assumes reload has priority over expiry on the same edge.
module wdt_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    // Expiry only when running, at zero, and not serviced this cycle.
    assign expire = run && (count == '0) && !reload;

    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (reload)
            count <= load_val;
        else if (run) begin
            if (count == '0)
                count <= load_val;
            else
                count <= count - 1'b1;
        end
    end

    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> $stable(count));
    assert_reload_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == $past(load_val)));
endmodule

// File: rtl/wdt_pulse_gen.sv
// Pulse generator: each fire starts (or restarts) a pulse of PULSE_LEN cycles.
// Assumes PULSE_LEN >= 1.
module wdt_pulse_gen #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

    logic [PW-1:0] remain;

    // Remaining pulse cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (fire)
            remain <= LEN;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign pulse = (remain != '0);

    assert_pulse_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pulse);
endmodule

// File: rtl/wdt_trip_acct.sv
// Trip accounting: sticky status, saturating expiry count and the held
// reset latch. Cleared only by the hardware reset input.
// Assumes a limit of zero means the latch is never armed.
module wdt_trip_acct #(
    parameter int TRIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic [TRIP_W-1:0] limit,
    output logic [TRIP_W-1:0] trips,
    output logic              status,
    output logic              held
);
    localparam logic [TRIP_W-1:0] TRIP_MAX = '1;

    logic [TRIP_W-1:0] trips_nx;

    // Saturating next trip value.
    assign trips_nx = (trips == TRIP_MAX) ? trips : trips + 1'b1;

    // Status, trip count and latch update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trips  <= '0;
            status <= 1'b0;
            held   <= 1'b0;
        end else if (expire) begin
            trips  <= trips_nx;
            status <= 1'b1;
            if ((limit != '0) && (trips_nx >= limit))
                held <= 1'b1;
        end
    end

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status |=> status);
    assert_trips_no_decrease_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (trips >= $past(trips)));
    assert_held_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> held);
    assert_no_hold_limit0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0 && !held) |=> !held);
endmodule

// File: rtl/wdt_trip_top.sv
// Watchdog top: register file, service-key decode, and the joining of the
// counter, pulse generator and trip accounting into one reset output.
// Assumes single-cycle writes and a combinational read port.
module wdt_trip_top #(
    parameter int CNT_W     = 32,
    parameter int TRIP_W    = 8,
    parameter int PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             rst_out
);
    import wdt_pkg::*;

    localparam int PAD_W = CNT_W - 2 * TRIP_W;

    logic              enable;
    logic [CNT_W-1:0]  load_reg;
    logic [TRIP_W-1:0] limit;
    logic [CNT_W-1:0]  count;
    logic [TRIP_W-1:0] trips;
    logic              status, held, expire, pulse;
    logic              wr_ctrl, svc_ok, en_rise, reload, run;

    // Write decode and the service-key match.
    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    assign en_rise = wr_ctrl && wr_data[CTRL_EN_BIT] && !enable;
    assign svc_ok  = wr_en && (wr_addr == ADDR_SVC) && (wr_data == CNT_W'(SVC_KEY))
                     && enable && !held;
    assign reload  = en_rise || svc_ok;
    assign run     = enable && !held;

    // Software-writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            load_reg <= '0;
            limit    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: enable   <= wr_data[CTRL_EN_BIT];
                ADDR_LOAD: load_reg <= wr_data;
                ADDR_TRIP: limit    <= wr_data[TRIP_W-1:0];
                default:   ;
            endcase
        end
    end

    wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .reload(reload),
        .load_val(load_reg), .count(count), .expire(expire)
    );

    wdt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(expire), .pulse(pulse)
    );

    wdt_trip_acct #(.TRIP_W(TRIP_W)) u_trip (
        .clk(clk), .rst_n(rst_n), .expire(expire), .limit(limit),
        .trips(trips), .status(status), .held(held)
    );

    assign rst_out = pulse || held;

    // Combinational read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL: begin
                rd_data[CTRL_EN_BIT]   = enable;
                rd_data[CTRL_STAT_BIT] = status;
            end
            ADDR_LOAD: rd_data = load_reg;
            ADDR_SVC:  rd_data = count;
            ADDR_TRIP: rd_data = {{PAD_W{1'b0}}, trips, limit};
            default:   rd_data = '0;
        endcase
    end

    assert_held_drives_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> rst_out);
    assert_service_blocks_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ok && !pulse && !held) |=> !rst_out);
    assert_off_no_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !pulse && !held) |=> !rst_out);
endmodule

// File: tb/wdt_trip_top_tb.sv
module wdt_trip_top_tb;
    localparam logic [31:0] KEY = 32'h5AC3_3CA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rst_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    wdt_trip_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rst_out(rst_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hw_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        hw_reset();
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register zero", v, 32'h0);
        end
        chk("R1 rst_out low", {31'b0, rst_out}, 32'h0);
    endtask

    task automatic t_expiry_pulse();
        logic [31:0] v;
        hw_reset();
        wr(2'd1, 32'd40);
        wr(2'd0, 32'd1);
        rd(2'd2, v); chk("R2 loaded on enable", v, 32'd40);
        wait_cyc(5);
        rd(2'd2, v); chk("R2 counts down", v, 32'd35);
        wait_cyc(35);
        rd(2'd2, v); chk("R3 count zero", v, 32'd0);
        chk("R3 no pulse yet", {31'b0, rst_out}, 32'h0);
        wait_cyc(1);
        chk("R3 pulse rises", {31'b0, rst_out}, 32'h1);
        rd(2'd2, v); chk("R3 reloaded", v, 32'd40);
        wait_cyc(15);
        chk("R3 pulse still high at 16", {31'b0, rst_out}, 32'h1);
        wait_cyc(1);
        chk("R3 pulse ends", {31'b0, rst_out}, 32'h0);
        rd(2'd2, v); chk("R3 keeps counting", v, 32'd24);
        rd(2'd0, v); chk("R6 status set", v, 32'h3);
        rd(2'd3, v); chk("R7 one trip", v, 32'h0000_0100);
        wr(2'd0, 32'd0);
        rd(2'd0, v); chk("R6 write does not clear status", v, 32'h2);
        rd(2'd2, v);
        wait_cyc(7);
        begin
            logic [31:0] v2;
            rd(2'd2, v2); chk("R2 holds when disabled", v2, v);
        end
    endtask

    task automatic t_service();
        logic [31:0] v, c;
        hw_reset();
        wr(2'd1, 32'd20);
        wr(2'd0, 32'd1);
        wait_cyc(20);
        rd(2'd2, v); chk("R5 count at zero", v, 32'd0);
        wr(2'd2, KEY);
        chk("R5 no pulse on service-at-zero", {31'b0, rst_out}, 32'h0);
        rd(2'd2, v); chk("R5 reloaded", v, 32'd20);
        rd(2'd0, v); chk("R5 status clear", v, 32'h1);
        rd(2'd3, v); chk("R5 no trip", v, 32'h0);
        wr(2'd2, 32'h1234_5678);
        rd(2'd2, v); chk("R4 wrong key ignored", v, 32'd19);
        wait_cyc(3);
        wr(2'd2, KEY);
        rd(2'd2, v); chk("R4 key reloads", v, 32'd20);
        for (int i = 0; i < 6; i++) begin
            wait_cyc(15);
            wr(2'd2, KEY);
        end
        chk("R4 serviced no reset", {31'b0, rst_out}, 32'h0);
        wr(2'd0, 32'd0);
        rd(2'd2, c);
        wr(2'd2, KEY);
        rd(2'd2, v); chk("R4 key ignored when disabled", v, c);
    endtask

    task automatic t_trip_latch();
        logic [31:0] v, c;
        hw_reset();
        wr(2'd3, 32'd2);
        wr(2'd1, 32'd5);
        wr(2'd0, 32'd1);
        wait_cyc(6);
        chk("R7 first expiry pulse", {31'b0, rst_out}, 32'h1);
        rd(2'd3, v); chk("R7 trip one", v, 32'h0000_0102);
        wait_cyc(6);
        rd(2'd3, v); chk("R7 trip two kept over pulse", v, 32'h0000_0202);
        wait_cyc(40);
        chk("R8 held past pulse", {31'b0, rst_out}, 32'h1);
        rd(2'd2, c);
        wait_cyc(5);
        rd(2'd2, v); chk("R8 counter frozen", v, c);
        hw_reset();
        chk("R10 held cleared", {31'b0, rst_out}, 32'h0);
        rd(2'd3, v); chk("R10 trips cleared", v, 32'h0);
        rd(2'd0, v); chk("R10 status and enable cleared", v, 32'h0);
    endtask

    task automatic t_limit_zero();
        logic [31:0] v;
        hw_reset();
        wr(2'd1, 32'd3);
        wr(2'd0, 32'd1);
        wait_cyc(16);
        rd(2'd3, v); chk("R9 four trips limit zero", v, 32'h0000_0400);
        wr(2'd0, 32'd0);
        wait_cyc(20);
        chk("R9 no hold with limit zero", {31'b0, rst_out}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_expiry_pulse();
        t_service();
        t_trip_latch();
        t_limit_zero();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule